// File: doc/BRIEF.md
# Single-Pass Multi-Configuration Cache Evaluator

This block listens to a processor's stream of data addresses and, without ever holding the processor back, works out for each access whether each cache in a family of candidates would have hit. The candidates differ in line size (1, 2 or 4 words of 8 bytes), in capacity (1 to 8 lines when fully associative) and in organisation (1, 2 or 4 ways over 2 or 4 sets). The block runs a single pass over the trace. It does not simulate each cache on its own. Instead, for every line size it keeps a most-recently-used stack of block addresses and searches it by content. From the position where a block is found, it reads off at once the caches that would hold it: the count of distinct blocks touched since its last use, in total and within its own set.

Addresses enter through a small FIFO. A three-state controller drains it, one access at a time: ST_IDLE pops the next word address and moves to ST_LOOKUP when the FIFO is not empty. ST_LOOKUP captures the search results of all stacks and always moves to ST_COMMIT. ST_COMMIT bumps the matching hit counters, reorders the stacks and returns to ST_IDLE. A synchronous clear sends the controller to ST_IDLE from any state. Software reads the hit counters at any time through an index port.

Top module: `cache_tuner_eval`

## Requirements
- R1: The three least significant address bits are discarded to form a word address. The block address for line-size index b (0, 1, 2 meaning 1, 2, 4 words) is the word address shifted right by b.
- R2: Fully associative counter index is b*8 + (L-1) for L lines, L = 1..8. It is incremented when the block was seen before and fewer than L distinct other blocks of that line size were referenced since its previous use.
- R3: Set-associative counter index is 24 + b*6 + w*2 + s, for 2^w ways (w = 0..2) and 2<<s sets (s = 0..1). The set is the low bits of the block address. The counter is incremented when fewer than 2^w distinct other blocks of the same set were referenced since the block's previous use.
- R4: Each recency stack holds 8 blocks. A first reference, or a block preceded by 8 or more distinct others since its last use, is a miss in every configuration.
- R5: For the byte addresses 0, 8, 16, 0, 8, 0, 16, the fully associative counters read 0,1,4,4,4,4,4,4 for 1-word lines, 3,5,5,5,5,5,5,5 for 2-word lines and 6 in all eight for 4-word lines.
- R6: An address strobe is never refused while the FIFO has room. A strobe that arrives when it is full is dropped and sets the overflow output, which stays high until a clear.
- R7: A clear zeroes every counter, empties every stack and the FIFO, and drops the overflow output. An address strobe in the same cycle as a clear is discarded.
- R8: Counters saturate at 2^CNT_W-1.
- R9: The read port returns counter rd_idx in the same cycle, and returns zero for any index of 42 or above.
- R10: Into an empty FIFO and an idle controller, an access accepted at clock edge 0 is visible on the read port after edge 3 and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, stacks, FIFO and overflow |
| acc_valid | input | 1 | Address strobe from the monitored processor |
| acc_addr | input | ADDR_W | Byte address of the access |
| rd_idx | input | 6 | Counter select |
| rd_cnt | output | CNT_W | Selected hit counter |
| ovf | output | 1 | Sticky flag: an address was lost to a full FIFO |

## Verification
A clear and an address strobe can land in the same cycle, and the clear must win: the FIFO stays empty and nothing reaches the stacks. The bench raises both together with address 0 after a long trace, then reads every counter back as zero. It then sends address 0 once more and requires that the counters stay at zero, because a second access to the same block would have hit if the discarded strobe had been kept. A following repeat then checks the three-edge latency.

// File: rtl/cte_pkg.sv
package cte_pkg;
    localparam int BYTE_SHIFT  = 3;
    localparam int NUM_LS      = 3;
    localparam int STK_DEPTH   = 8;
    localparam int POS_W       = $clog2(STK_DEPTH);
    localparam int NUM_WAY_OPT = 3;
    localparam int NUM_SET_OPT = 2;
    localparam int FA_CNT      = NUM_LS * STK_DEPTH;
    localparam int SA_PER_LS   = NUM_WAY_OPT * NUM_SET_OPT;
    localparam int SA_CNT      = NUM_LS * SA_PER_LS;
    localparam int NUM_CNT     = FA_CNT + SA_CNT;
    localparam int IDX_W       = $clog2(NUM_CNT);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_COMMIT
    } eval_state_t;
endpackage

// File: rtl/cte_addr_fifo.sv
module cte_addr_fifo #(
    parameter int W     = 29,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             full, do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + {{(CNT_W-1){1'b0}}, do_push} - {{(CNT_W-1){1'b0}}, do_pop};
            if (push && full) ovf <= 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R6
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH)); // R6
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !ovf)); // R7
endmodule

// File: rtl/cte_mru_stack.sv
module cte_mru_stack import cte_pkg::*; #(
    parameter int WORD_W = 29,
    parameter int SHIFT  = 0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr,
    input  logic [WORD_W-1:0]                     word_addr,
    input  logic                                  upd,
    output logic                                  hit,
    output logic [POS_W-1:0]                      pos,
    output logic [NUM_SET_OPT-1:0][POS_W-1:0]     ss_cnt
);
    logic [WORD_W-1:0]                 blk;
    logic [STK_DEPTH-1:0][WORD_W-1:0]  ent;
    logic [STK_DEPTH-1:0]              vld;
    logic [STK_DEPTH-1:0]              match;
    int                                lim;

    assign blk = word_addr >> SHIFT;

    always_comb begin
        for (int i = 0; i < STK_DEPTH; i++) begin
            match[i] = vld[i] && (ent[i] == blk);
        end
        hit = |match;
        pos = '0;
        for (int i = 0; i < STK_DEPTH; i++) begin
            if (match[i]) pos = POS_W'(i);
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SET_OPT; s++) begin
            ss_cnt[s] = '0;
            for (int i = 0; i < STK_DEPTH; i++) begin
                if (i < int'(pos) && vld[i] &&
                    (((ent[i] ^ blk) & WORD_W'((2 << s) - 1)) == '0)) begin
                    ss_cnt[s] = ss_cnt[s] + 1'b1;
                end
            end
        end
    end

    assign lim = hit ? int'(pos) : STK_DEPTH - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent <= '0;
            vld <= '0;
        end else if (clr) begin
            ent <= '0;
            vld <= '0;
        end else if (upd) begin
            ent[0] <= blk;
            vld[0] <= 1'b1;
            for (int i = 1; i < STK_DEPTH; i++) begin
                if (i <= lim) begin
                    ent[i] <= ent[i-1];
                    vld[i] <= vld[i-1];
                end
            end
        end
    end

    AST_CAM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R4
    AST_MRU_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> (vld[0] && ent[0] == $past(blk))); // R4
endmodule

// File: rtl/cte_hit_table.sv
module cte_hit_table import cte_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_CNT-1:0] inc_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CNT_W-1:0]   rd_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt [NUM_CNT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           cnt[g] <= '0;
            else if (clr)                         cnt[g] <= '0;
            else if (inc_en[g] && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + 1'b1;
        end

        AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == CNT_MAX && !clr) |=> cnt[g] == CNT_MAX); // R8
        AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> cnt[g] == '0); // R7
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (cnt[g] == $past(cnt[g]) || cnt[g] == $past(cnt[g]) + 1'b1)); // R2
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_idx == IDX_W'(i)) rd_val = cnt[i];
        end
    end
endmodule

// File: rtl/cache_tuner_eval.sv
module cache_tuner_eval import cte_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              ovf
);
    localparam int WORD_W = ADDR_W - BYTE_SHIFT;

    eval_state_t state, nxt;
    logic              f_empty, pop, lk_load, commit;
    logic [WORD_W-1:0] f_dout, cur_word;
    logic              unused_lo;

    logic [NUM_LS-1:0]                             st_hit, lk_hit;
    logic [NUM_LS-1:0][POS_W-1:0]                  st_pos, lk_pos;
    logic [NUM_LS-1:0][NUM_SET_OPT-1:0][POS_W-1:0] st_ss, lk_ss;
    logic [NUM_CNT-1:0]                            inc_en;

    assign unused_lo = ^acc_addr[BYTE_SHIFT-1:0];

    cte_addr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (acc_valid),
        .din   (acc_addr[ADDR_W-1:BYTE_SHIFT]),
        .pop   (pop),
        .dout  (f_dout),
        .empty (f_empty),
        .ovf   (ovf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!f_empty) nxt = ST_LOOKUP;
            ST_LOOKUP: nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        pop     = 1'b0;
        lk_load = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_IDLE:   pop     = !f_empty && !clr;
            ST_LOOKUP: lk_load = !clr;
            ST_COMMIT: commit  = !clr;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_word <= '0;
            lk_hit   <= '0;
            lk_pos   <= '0;
            lk_ss    <= '0;
        end else begin
            if (pop) cur_word <= f_dout;
            if (lk_load) begin
                lk_hit <= st_hit;
                lk_pos <= st_pos;
                lk_ss  <= st_ss;
            end
        end
    end

    for (genvar b = 0; b < NUM_LS; b++) begin : g_ls
        cte_mru_stack #(.WORD_W(WORD_W), .SHIFT(b)) i_stack (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .word_addr (cur_word),
            .upd       (commit),
            .hit       (st_hit[b]),
            .pos       (st_pos[b]),
            .ss_cnt    (st_ss[b])
        );

        for (genvar l = 0; l < STK_DEPTH; l++) begin : g_fa
            assign inc_en[b*STK_DEPTH + l] =
                commit && lk_hit[b] && (lk_pos[b] <= POS_W'(l));
        end

        for (genvar w = 0; w < NUM_WAY_OPT; w++) begin : g_way
            for (genvar s = 0; s < NUM_SET_OPT; s++) begin : g_set
                assign inc_en[FA_CNT + b*SA_PER_LS + w*NUM_SET_OPT + s] =
                    commit && lk_hit[b] &&
                    ({1'b0, lk_ss[b][s]} < (POS_W+1)'(1 << w));
            end
        end
    end

    cte_hit_table #(.CNT_W(CNT_W)) i_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .inc_en (inc_en),
        .rd_idx (rd_idx),
        .rd_val (rd_cnt)
    );

    AST_LOOKUP_TO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && !clr) |=> state == ST_COMMIT); // R10
    AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && !clr) |=> state == ST_IDLE); // R10
    AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state == ST_IDLE); // R7
    AST_NO_INC_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |-> inc_en == '0); // R10
endmodule

// File: tb/test_cache_tuner_eval.sv
module test_cache_tuner_eval;
    localparam int CLK_P  = 10;
    localparam int NCNT   = 42;

    localparam logic [31:0] WX_ADDR [7] = '{32'd0, 32'd8, 32'd16, 32'd0, 32'd8, 32'd0, 32'd16};
    localparam int WX_FA [24] = '{0,1,4,4,4,4,4,4, 3,5,5,5,5,5,5,5, 6,6,6,6,6,6,6,6};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_cnt;
    logic        ovf;

    logic        s_valid = 1'b0;
    logic [31:0] s_addr = '0;
    logic [5:0]  s_idx = '0;
    logic [2:0]  s_cnt;
    logic        s_ovf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int exp_c [NCNT];
    int hist [256];
    int hcnt = 0;

    always #(CLK_P/2) clk = ~clk;

    cache_tuner_eval i_cache_tuner_eval (
        .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .rd_idx(rd_idx), .rd_cnt(rd_cnt), .ovf(ovf)
    );

    cache_tuner_eval #(.CNT_W(3)) i_cache_tuner_eval_sat (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .acc_valid(s_valid),
        .acc_addr(s_addr), .rd_idx(s_idx), .rd_cnt(s_cnt), .ovf(s_ovf)
    );

    task automatic check(input string tag, input int got, input int want);
        tests++;
        if (got != want) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, want);
        end
    endtask

    task automatic chk_cnt(input int idx, input int want, input string tag);
        rd_idx = 6'(idx);
        #1;
        tests++;
        if (rd_cnt !== 32'(want)) begin
            fails++;
            $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, rd_cnt, want);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NCNT; i++) exp_c[i] = 0;
        hcnt = 0;
    endtask

    // reference: distinct blocks since the previous use, in total and per set
    task automatic model_access(input logic [31:0] addr);
        int word, blk, nd, c, sets;
        int dl [8];
        bit found;
        word = int'(addr >> 3);
        for (int ls = 0; ls < 3; ls++) begin
            blk = word >> ls;
            nd = 0;
            found = 1'b0;
            for (int j = hcnt - 1; j >= 0 && !found && nd < 8; j--) begin
                int b;
                bit seen;
                b = hist[j] >> ls;
                if (b == blk) found = 1'b1;
                else begin
                    seen = 1'b0;
                    for (int k = 0; k < nd; k++) if (dl[k] == b) seen = 1'b1;
                    if (!seen) begin dl[nd] = b; nd++; end
                end
            end
            if (found) begin
                for (int l = 1; l <= 8; l++) if (nd < l) exp_c[ls*8 + l - 1]++;
                for (int w = 0; w < 3; w++) begin
                    for (int s = 0; s < 2; s++) begin
                        sets = 2 << s;
                        c = 0;
                        for (int k = 0; k < nd; k++) if ((dl[k] % sets) == (blk % sets)) c++;
                        if (c < (1 << w)) exp_c[24 + ls*6 + w*2 + s]++;
                    end
                end
            end
        end
        hist[hcnt] = word;
        hcnt++;
    endtask

    task automatic send(input logic [31:0] addr);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = addr;
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_access(addr);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NCNT; i++) chk_cnt(i, exp_c[i], tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state and out-of-range index
        check_all("R9 reset");
        chk_cnt(63, 0, "R9 out-of-range index");
        check("R6 ovf after reset", int'(ovf), 0);

        // R5: worked example from the vector table
        for (int v = 0; v < 7; v++) send(WX_ADDR[v]);
        for (int i = 0; i < 24; i++) chk_cnt(i, WX_FA[i], "R5 worked example");
        check_all("R3 set-assoc after worked example");

        // R1 R2 R3 R4: longer trace with byte offsets, evictions and set conflicts
        for (int k = 0; k < 60; k++) begin
            send(32'((((k*5) % 11) + (k/20)*16) * 8 + (k % 8)));
        end
        check_all("R2/R3/R4 long trace");
        check("R6 no overflow at spaced rate", int'(ovf), 0);

        // R7: clear together with a strobe; the strobe is discarded
        @(negedge clk);
        clr = 1'b1; acc_valid = 1'b1; acc_addr = 32'd0;
        @(negedge clk);
        clr = 1'b0; acc_valid = 1'b0;
        repeat (4) @(negedge clk);
        model_clear();
        check_all("R7 counters after clear");
        send(32'd0);
        chk_cnt(0, 0, "R7 strobe with clear discarded");

        // R10: latency of a hit
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'd0;
        @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_cnt(0, 0, "R10 not visible after edge 2");
        @(negedge clk);
        chk_cnt(0, 1, "R10 visible after edge 3");
        model_access(32'd0);
        check_all("R10 full table after hit");

        // R8: saturation on the narrow-counter instance
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_addr = 32'd0;
            @(negedge clk);
            s_valid = 1'b0;
            repeat (3) @(negedge clk);
        end
        s_idx = 6'd0;
        #1;
        check("R8 saturation 1 line", int'(s_cnt), 7);
        s_idx = 6'd23;
        #1;
        check("R8 saturation 4-word 8 lines", int'(s_cnt), 7);

        // R6: burst overflows the FIFO
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            acc_valid = 1'b1;
            acc_addr  = 32'(k * 64);
        end
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (40) @(negedge clk);
        check("R6 overflow raised", int'(ovf), 1);

        // R7: clear drops overflow and counters
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        #1;
        check("R7 overflow cleared", int'(ovf), 0);
        chk_cnt(0, 0, "R7 counter cleared");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule